// File: doc/BRIEF.md
# Serial Register Access Port for a Multi-Channel Converter

This block is the serial front end that lets a host processor reach the register map of an eight-channel converter. The host frames each transaction with an active-high chip enable and clocks bits with a serial clock that idles low. Data moves most significant bit first in both directions. The first byte after chip enable rises is a command byte. Its top bit picks write or read, and its low five bits name a register. Every later byte in the same enable window is a data byte for that command.

All four serial pins are oversampled in the system clock domain. Writes come out as one-cycle strobes that carry an address and a data byte. Reads come out as one-cycle requests, and the register file answers combinationally in the same cycle. A command that names a register in the conversion-result array (addresses 0x00 to 0x0F, two bytes per channel) also loads the converter's channel pointer.

Read bursts step through a result pair and then jump to the next channel whose enable bit is set. Disabled channels are skipped, and the search wraps from the top channel to channel 0. Above the result array the addresses simply count up.

Top module: `spi_reg_port`

## Requirements
- R1: While chip enable is low, `spi_miso_oe` is 0, no write or read strobe is issued and serial clock edges are ignored; a few system clocks after chip enable rises, `spi_miso_oe` is 1.
- R2: The first complete byte after chip enable rises is always taken as the command byte; a partial byte cut off by chip enable falling is discarded.
- R3: Command byte encoding: bit 7 = 1 means write and 0 means read, bits 4:0 give the register address, and bits 6:5 are ignored. MOSI is sampled on the falling SCK edge, MSB first.
- R4: In a write command, each later complete byte gives exactly one `wr_stb` pulse with `wr_addr` set to the command address and `wr_data` set to the received byte. The write address does not advance, and a write command issues no read strobe.
- R5: A read command issues `rd_stb` at the command address, and `rd_data` is taken in that same cycle. The fetched byte is shifted out MSB first during the next byte, with each MISO bit changing on a rising SCK edge.
- R6: A command byte whose address is below 0x10 pulses `ptr_load` once, with `ptr_chan` = address bits 3:1. A command address of 0x10 or above gives no pulse.
- R7: After each data byte of a read, the port issues `rd_stb` at the next address. From an even result address, the next address is +1. From an odd result address, the next address is byte 0 of the next channel above whose `chan_en` bit is set, wrapping from channel 7 to channel 0. That channel change also pulses `ptr_load` with the new channel.
- R8: When no other channel is enabled, a burst read leaving the second byte of a pair returns to byte 0 of the same channel.
- R9: In a burst read at addresses 0x10 and above, the address increments by one, wrapping from 0x1F to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_ce | input | 1 | Chip enable, active high |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| chan_en | input | 8 | Per-channel enable bits used by burst reads |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 5 | Write register address |
| wr_data | output | 8 | Write data byte |
| rd_stb | output | 1 | One-cycle register read request |
| rd_addr | output | 5 | Read register address |
| rd_data | input | 8 | Read data, valid combinationally for `rd_addr` |
| ptr_load | output | 1 | One-cycle load of the converter channel pointer |
| ptr_chan | output | 3 | Channel value to load |

## Verification
The bench sweeps every start address of the result array against several channel-enable patterns. These include all channels on, the two end channels only, a sparse pattern and none at all. It checks each byte shifted out and each address requested against an arithmetic model of the skip rule. Any error in the wrap from channel 7 to channel 0, or in the empty-set fallback, shows up as a wrong address or a wrong byte.

A partial byte is aborted by chip enable and followed by a fresh write. A design that keeps its bit count across enable windows would misframe that write. Command bytes with the ignored bits set must still decode to the right address, and writes must never advance. Serial clock toggled while disabled must leave no strobe behind.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int NUM_CH    = 8;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int DATA_SPAN = 2 * NUM_CH;
    localparam int CNT_W     = $clog2(BYTE_W);

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.is_wr = b[BYTE_W-1];
        c.addr  = b[ADDR_W-1:0];
        return c;
    endfunction

    function automatic logic in_result_array(input logic [ADDR_W-1:0] a);
        return a < ADDR_W'(DATA_SPAN);
    endfunction

    // Address that follows a burst read byte: step within a pair, then hop to
    // the next enabled channel (cyclic); stay on the same channel if none.
    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                     input logic [NUM_CH-1:0] en);
        logic [CH_W-1:0]   ch;
        logic [CH_W-1:0]   cand;
        logic              found;
        logic [ADDR_W-1:0] res;
        res = a + 1'b1;
        if (in_result_array(a) && a[0]) begin
            ch    = a[CH_W:1];
            found = 1'b0;
            res   = ADDR_W'({ch, 1'b0});
            for (int k = 1; k <= NUM_CH; k++) begin
                cand = ch + CH_W'(k);
                if (!found && en[cand]) begin
                    found = 1'b1;
                    res   = ADDR_W'({cand, 1'b0});
                end
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_raw,
    input  logic ce_raw,
    input  logic mosi_raw,
    output logic ce_act,
    output logic mosi_s,
    output logic sck_rise,
    output logic sck_fall
);
    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] ce_p;
    logic [STAGES-1:0] mosi_p;
    logic              sck_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_p  <= '0;
                    ce_p   <= '0;
                    mosi_p <= '0;
                end else begin
                    sck_p  <= sck_raw;
                    ce_p   <= ce_raw;
                    mosi_p <= mosi_raw;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_p  <= '0;
                    ce_p   <= '0;
                    mosi_p <= '0;
                end else begin
                    sck_p  <= {sck_p[STAGES-2:0], sck_raw};
                    ce_p   <= {ce_p[STAGES-2:0], ce_raw};
                    mosi_p <= {mosi_p[STAGES-2:0], mosi_raw};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck_p[STAGES-1];
    end

    assign ce_act   = ce_p[STAGES-1];
    assign mosi_s   = mosi_p[STAGES-1];
    assign sck_rise = sck_p[STAGES-1] & ~sck_q;
    assign sck_fall = ~sck_p[STAGES-1] & sck_q;
endmodule

// File: rtl/spi_shift.sv
module spi_shift
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_act,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic              load_tx,
    input  logic [BYTE_W-1:0] tx_val,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso_bit
);
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;

    always_ff @(posedge clk) begin
        if (rst || !ce_act) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            miso_bit  <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (sck_fall) begin
                rx_sr   <= {rx_sr[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(BYTE_W - 1)) byte_done <= 1'b1;
            end
            if (sck_rise) begin
                miso_bit <= tx_sr[BYTE_W-1];
                tx_sr    <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
            if (load_tx) tx_sr <= tx_val;
        end
    end

    assign rx_byte = rx_sr;
endmodule

// File: rtl/spi_txn_ctrl.sv
module spi_txn_ctrl
    import spi_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_act,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              ptr_load,
    output logic [CH_W-1:0]   ptr_chan,
    output logic              load_tx,
    output logic [BYTE_W-1:0] tx_val
);
    phase_e            phase;
    cmd_t              cur;
    cmd_t              cmd;
    logic [ADDR_W-1:0] nxt;

    assign cmd = decode_cmd(rx_byte);
    assign nxt = next_addr(cur.addr, chan_en);

    always_ff @(posedge clk) begin
        if (rst || !ce_act) begin
            phase    <= PH_CMD;
            cur      <= '0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            rd_stb   <= 1'b0;
            rd_addr  <= '0;
            ptr_load <= 1'b0;
            ptr_chan <= '0;
        end else begin
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
            ptr_load <= 1'b0;
            if (byte_done) begin
                unique case (phase)
                    PH_CMD: begin
                        cur   <= cmd;
                        phase <= PH_DATA;
                        if (in_result_array(cmd.addr)) begin
                            ptr_load <= 1'b1;
                            ptr_chan <= cmd.addr[CH_W:1];
                        end
                        if (!cmd.is_wr) begin
                            rd_stb  <= 1'b1;
                            rd_addr <= cmd.addr;
                        end
                    end
                    PH_DATA: begin
                        if (cur.is_wr) begin
                            wr_stb  <= 1'b1;
                            wr_addr <= cur.addr;
                            wr_data <= rx_byte;
                        end else begin
                            cur.addr <= nxt;
                            rd_stb   <= 1'b1;
                            rd_addr  <= nxt;
                            if (in_result_array(cur.addr) && cur.addr[0]) begin
                                ptr_load <= 1'b1;
                                ptr_chan <= nxt[CH_W:1];
                            end
                        end
                    end
                    default: phase <= PH_CMD;
                endcase
            end
        end
    end

    // Register file answers in the cycle of the request; capture it then.
    assign load_tx = rd_stb;
    assign tx_val  = rd_data;
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
    import spi_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_ce,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [NUM_CH-1:0] chan_en,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              ptr_load,
    output logic [CH_W-1:0]   ptr_chan
);
    logic              ce_act;
    logic              mosi_s;
    logic              sck_rise;
    logic              sck_fall;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              load_tx;
    logic [BYTE_W-1:0] tx_val;

    spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_raw  (spi_sck),
        .ce_raw   (spi_ce),
        .mosi_raw (spi_mosi),
        .ce_act   (ce_act),
        .mosi_s   (mosi_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    spi_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .ce_act    (ce_act),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .mosi_s    (mosi_s),
        .load_tx   (load_tx),
        .tx_val    (tx_val),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso_bit  (spi_miso)
    );

    spi_txn_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ce_act    (ce_act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .chan_en   (chan_en),
        .rd_data   (rd_data),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_stb    (rd_stb),
        .rd_addr   (rd_addr),
        .ptr_load  (ptr_load),
        .ptr_chan  (ptr_chan),
        .load_tx   (load_tx),
        .tx_val    (tx_val)
    );

    assign spi_miso_oe = ce_act;
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk
    import spi_port_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              spi_ce,
    input logic              spi_miso,
    input logic              spi_miso_oe,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              ptr_load,
    input logic [CH_W-1:0]   ptr_chan,
    input logic              sck_rise,
    input logic              ce_act
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)            cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 1'b1;
    end

    // R1: chip enable held low for three cycles turns the MISO driver off
    p_oe_off_r1: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3 && !spi_ce && !$past(spi_ce) && !$past(spi_ce, 2)) |-> !spi_miso_oe);

    // R1: no strobe while the port was disabled in the previous cycle
    p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (cyc != 2'd0 && !$past(spi_miso_oe)) |-> (!wr_stb && !rd_stb));

    // R4: one command is either a write or a read, never both in a cycle
    p_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && rd_stb));

    // R5: MISO moves only after a rising serial clock edge
    p_miso_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && $past(ce_act) && !$past(sck_rise)) |-> $stable(spi_miso));

    // R6: a pointer load that comes with a read names the read's channel
    p_ptr_rd_r6: assert property (@(posedge clk) disable iff (rst)
        (ptr_load && rd_stb) |-> (rd_addr[CH_W:1] == ptr_chan));
endmodule

bind spi_reg_port spi_reg_port_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_ce      (spi_ce),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .wr_stb      (wr_stb),
    .rd_stb      (rd_stb),
    .rd_addr     (rd_addr),
    .ptr_load    (ptr_load),
    .ptr_chan    (ptr_chan),
    .sck_rise    (sck_rise),
    .ce_act      (ce_act)
);

// File: tb/spi_reg_port_test.sv
module spi_reg_port_test;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce = 1'b0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic [7:0] chan_en = 8'hFF;
    logic       miso, miso_oe, wr_stb, rd_stb, ptr_load;
    logic [4:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic [2:0] ptr_chan;

    int n_chk = 0;
    int n_err = 0;
    int wr_n = 0, rd_n = 0, ptr_n = 0;
    logic [4:0] wr_log_a [0:63];
    logic [7:0] wr_log_d [0:63];
    logic [4:0] rd_log   [0:1023];
    logic [2:0] ptr_log  [0:1023];

    always #5 clk = ~clk;

    function automatic logic [7:0] model(input logic [4:0] a);
        return {a, 3'b000} ^ 8'h5A;
    endfunction

    assign rd_data = model(rd_addr);

    spi_reg_port uut (
        .clk(clk), .rst(rst), .spi_ce(ce), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .chan_en(chan_en),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
        .ptr_load(ptr_load), .ptr_chan(ptr_chan)
    );

    always @(negedge clk) begin
        if (wr_stb && wr_n < 64) begin
            wr_log_a[wr_n] = wr_addr; wr_log_d[wr_n] = wr_data; wr_n++;
        end
        if (rd_stb && rd_n < 1024) begin rd_log[rd_n] = rd_addr; rd_n++; end
        if (ptr_load && ptr_n < 1024) begin ptr_log[ptr_n] = ptr_chan; ptr_n++; end
    end

    function automatic logic [4:0] exp_next(input logic [4:0] a, input logic [7:0] en);
        int ch;
        if (a >= 5'd16 || a[0] == 1'b0) return a + 5'd1;
        ch = int'(a[3:1]);
        for (int k = 1; k <= 8; k++) begin
            int c = (ch + k) % 8;
            if (en[c]) return 5'(2 * c);
        end
        return 5'(2 * ch);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk); sck = 1'b1; mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic ce_on();
        @(negedge clk); ce = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic ce_off();
        @(negedge clk); ce = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic burst(input logic [4:0] start, input logic [7:0] en, input int n);
        logic [4:0] e, nx;
        logic [7:0] r;
        int rb, pb, np;
        logic [2:0] exp_p [0:31];
        chan_en = en; rb = rd_n; pb = ptr_n; np = 0;
        ce_on();
        xfer({3'b000, start}, r);
        e = start;
        if (e < 5'd16) begin exp_p[np] = e[3:1]; np++; end
        for (int j = 0; j < n; j++) begin
            xfer(8'h00, r);
            chk(rd_log[rb + j] == e, "R7 read address", rd_log[rb + j], e);
            chk(r == model(e), "R5 read byte", r, model(e));
            nx = exp_next(e, en);
            if (e < 5'd16 && e[0]) begin exp_p[np] = nx[3:1]; np++; end
            e = nx;
        end
        ce_off();
        chk(rd_n - rb == n + 1, "R7 read count", rd_n - rb, n + 1);
        chk(ptr_n - pb == np, "R6 pointer load count", ptr_n - pb, np);
        if (ptr_n - pb == np)
            for (int j = 0; j < np; j++)
                chk(ptr_log[pb + j] == exp_p[j], "R7 pointer channel", ptr_log[pb + j], exp_p[j]);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [7:0] r;
        int wb, rb, pb;
        logic [7:0] pats [0:3];
        pats[0] = 8'hFF; pats[1] = 8'h81; pats[2] = 8'h24; pats[3] = 8'h00;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(miso_oe == 1'b0, "R1 oe after reset", miso_oe, 0);
        chk(wr_n == 0 && rd_n == 0 && ptr_n == 0, "R1 no strobes after reset", wr_n + rd_n + ptr_n, 0);

        // R1: clocking with enable low does nothing
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sck = 1'b1; mosi = 1'b0;
            repeat (HALF) @(negedge clk); sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        chk(wr_n + rd_n + ptr_n == 0, "R1 ignored while disabled", wr_n + rd_n + ptr_n, 0);
        ce_on();
        chk(miso_oe == 1'b1, "R1 oe when enabled", miso_oe, 1);
        ce_off();
        chk(miso_oe == 1'b0, "R1 oe after disable", miso_oe, 0);

        // R4, R6: write to control address, address holds, no pointer load
        wb = wr_n; rb = rd_n; pb = ptr_n;
        ce_on(); xfer(8'h93, r); xfer(8'hA5, r); xfer(8'h3C, r); ce_off();
        chk(wr_n - wb == 2, "R4 write count", wr_n - wb, 2);
        chk(wr_log_a[wb] == 5'h13 && wr_log_a[wb + 1] == 5'h13, "R4 write address holds",
            wr_log_a[wb + 1], 5'h13);
        chk(wr_log_d[wb] == 8'hA5, "R4 first write data", wr_log_d[wb], 8'hA5);
        chk(wr_log_d[wb + 1] == 8'h3C, "R4 second write data", wr_log_d[wb + 1], 8'h3C);
        chk(rd_n == rb, "R4 no read in write", rd_n - rb, 0);
        chk(ptr_n == pb, "R6 no pointer load above array", ptr_n - pb, 0);

        // R6: write into result array loads the pointer
        pb = ptr_n;
        ce_on(); xfer(8'h86, r); xfer(8'h11, r); ce_off();
        chk(ptr_n - pb == 1 && ptr_log[pb] == 3'd3, "R6 pointer from command", ptr_log[pb], 3);

        // R2: partial byte discarded across an enable window
        wb = wr_n;
        ce_on();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); sck = 1'b1; mosi = 1'b1;
            repeat (HALF) @(negedge clk); sck = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        ce_off();
        ce_on(); xfer(8'h85, r); xfer(8'h77, r); ce_off();
        chk(wr_n - wb == 1, "R2 one write after abort", wr_n - wb, 1);
        chk(wr_log_a[wb] == 5'h05 && wr_log_d[wb] == 8'h77, "R2 framing after abort",
            {wr_log_a[wb], wr_log_d[wb]}, {5'h05, 8'h77});

        // R3: ignored bits 6:5 in a read command
        rb = rd_n;
        ce_on(); xfer(8'h65, r); xfer(8'h00, r); ce_off();
        chk(rd_log[rb] == 5'h05, "R3 command address decode", rd_log[rb], 5'h05);
        chk(r == model(5'h05), "R3 read data with ignored bits", r, model(5'h05));

        // R5, R7, R8: sweep start addresses over enable patterns
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 16; s++)
                burst(5'(s), pats[p], 5);

        // R9: control addresses count and wrap
        burst(5'h1E, 8'hFF, 4);
        burst(5'h10, 8'h00, 3);

        report();
        $finish;
    end
endmodule